// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block loads two connection memories, a local one and a backplane one, with a fixed pattern in a single pass. A host writes a 16-bit control word that carries a start bit and two 3-bit fill codes. The engine then sweeps every address of both memories and writes each entry. The upper three bits of a local entry receive the local code, the upper three bits of a backplane entry receive the backplane code, and the lower thirteen bits of every entry are cleared.

A sweep may begin at any slot position in a frame. It starts at the slot address presented on the frame-slot input and wraps through the address space, so it covers every entry exactly once in `DEPTH` cycles (one frame). At the end the start bit clears itself, and it reads back low to signal completion. The host can stop a sweep early by writing the start bit low, and the sweep also stops when the global master enable drops. Entries already swept keep the new pattern. Entries not yet reached keep their old contents.

The memory write ports are plain write strobes with address and data. The memories are synchronous RAMs that accept one write per cycle without stalling, so there is no back-pressure. The host port is a single-cycle write strobe with an always-valid read-back word.

Top module: `cmf_fill_engine`

## Requirements
- R1: After reset the read-back word is 0, `busy` and `done` are low, and no memory write strobe is raised.
- R2: The control word holds the start bit at bit 0, the local code at bits 3:1 and the backplane code at bits 6:4. Bits 15:7 always read 0. A write while idle stores both codes.
- R3: A host write with bit 0 set, while idle and with `master_en` high, starts a sweep. `busy` is high from the next cycle, and the first write goes to the slot address sampled with that host write.
- R4: With `master_en` low, a write with bit 0 set starts nothing. Bit 0 reads back 0 and no memory write occurs, but both codes are stored.
- R5: Every local write carries the local code in bits 15:13 and zeros in bits 12:0.
- R6: Every backplane write carries the backplane code in bits 15:13 and zeros in bits 12:0.
- R7: A sweep that is not stopped writes each address of both memories exactly once, one address per cycle in ascending order from the start slot with wrap-around, over `DEPTH` cycles.
- R8: When a sweep completes, `busy` drops and bit 0 reads back 0. In the same cycle `done` pulses high for exactly one cycle.
- R9: During a sweep, a host write that keeps bit 0 set is ignored. The codes and the pattern being written stay unchanged.
- R10: During a sweep, a host write with bit 0 clear stops the sweep at once. No memory write occurs in that cycle, `done` stays low, bit 0 reads back 0, and the stored codes are kept.
- R11: A sweep stops at once when `master_en` is low. No memory write occurs while it is low, and `busy` is low from the next cycle.
- R12: After a stop, the entries swept before it hold the fill pattern, and all other entries keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the control word |
| host_wr_data | input | 16 | Control word written by the host |
| host_rd_data | output | 16 | Current control word |
| master_en | input | 1 | Global enable for block filling |
| slot_cnt | input | AW | Current frame slot, used as the start address |
| loc_wr_en | output | 1 | Local memory write strobe |
| loc_wr_addr | output | AW | Local memory write address |
| loc_wr_data | output | 16 | Local memory write word |
| bp_wr_en | output | 1 | Backplane memory write strobe |
| bp_wr_addr | output | AW | Backplane memory write address |
| bp_wr_data | output | 16 | Backplane memory write word |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse on normal completion |

## Verification
Several properties are checked on every cycle:
- the reserved bits read zero;
- the start bit follows `busy`;
- each write word has the stored code in its top bits and zeros below;
- consecutive writes step the address by one with wrap, and no sweep exceeds `DEPTH` writes;
- the master enable gates all writes;
- the codes stay frozen while a sweep runs;
- a host stop suppresses the write in its own cycle;
- `done` is a single isolated pulse.

Only the bench scenarios can show the whole-memory result against bench-model RAMs:
- full coverage from arbitrary start slots, including the wrap from the last address;
- the exact boundary between swept and untouched entries after a stop at any point from zero writes to `DEPTH-1` writes;
- that ignored writes leave the final pattern unchanged.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int CTRL_W  = 16;
  localparam int CODE_W  = 3;
  localparam int START_B = 0;
  localparam int LOC_LSB = 1;
  localparam int BP_LSB  = 4;
  localparam int PAT_LSB = CTRL_W - CODE_W;

  typedef struct packed {
    logic [CODE_W-1:0] bp;
    logic [CODE_W-1:0] loc;
  } fill_cfg_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic start, input fill_cfg_t cfg);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[START_B] = start;
    w[LOC_LSB +: CODE_W] = cfg.loc;
    w[BP_LSB +: CODE_W] = cfg.bp;
    return w;
  endfunction

  function automatic logic [CTRL_W-1:0] fill_word(input logic [CODE_W-1:0] code);
    return {code, {PAT_LSB{1'b0}}};
  endfunction
endpackage

// File: rtl/cmf_ctrl_reg.sv
module cmf_ctrl_reg
  import cmf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              master_en,
  input  logic              sweep_last,
  output logic              start_now,
  output logic              abort_now,
  output logic              busy,
  output logic              done,
  output fill_cfg_t         cfg,
  output logic [CTRL_W-1:0] rd_data
);
  logic busy_q, done_q;
  fill_cfg_t cfg_q;

  assign start_now = wr_en & wr_data[START_B] & ~busy_q & master_en;
  assign abort_now = busy_q & (~master_en | (wr_en & ~wr_data[START_B]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (wr_en) begin
          cfg_q.loc <= wr_data[LOC_LSB +: CODE_W];
          cfg_q.bp  <= wr_data[BP_LSB +: CODE_W];
        end
        if (start_now) busy_q <= 1'b1;
      end else if (abort_now) begin
        busy_q <= 1'b0;
      end else if (sweep_last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign cfg     = cfg_q;
  assign rd_data = pack_ctrl(busy_q, cfg_q);
endmodule

// File: rtl/cmf_sweep.sv
module cmf_sweep #(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  logic [AW-1:0] addr_q, cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      addr_q <= start_addr;
      cnt_q  <= '0;
    end else if (step) begin
      addr_q <= (addr_q == TOP) ? '0 : addr_q + 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign addr = addr_q;
  assign last = (cnt_q == TOP);
endmodule

// File: rtl/cmf_mem_port.sv
module cmf_mem_port
  import cmf_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic              active,
  input  logic [AW-1:0]     addr,
  input  logic [CODE_W-1:0] code,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [CTRL_W-1:0] wr_data
);
  assign wr_en   = active;
  assign wr_addr = addr;
  assign wr_data = fill_word(code);
endmodule

// File: rtl/cmf_fill_engine.sv
module cmf_fill_engine
  import cmf_pkg::*;
#(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [CTRL_W-1:0] host_wr_data,
  output logic [CTRL_W-1:0] host_rd_data,
  input  logic              master_en,
  input  logic [AW-1:0]     slot_cnt,
  output logic              loc_wr_en,
  output logic [AW-1:0]     loc_wr_addr,
  output logic [CTRL_W-1:0] loc_wr_data,
  output logic              bp_wr_en,
  output logic [AW-1:0]     bp_wr_addr,
  output logic [CTRL_W-1:0] bp_wr_data,
  output logic              busy,
  output logic              done
);
  localparam int NBANK = 2;

  logic start_now, abort_now, sweep_last, active;
  logic [AW-1:0] sweep_addr;
  fill_cfg_t cfg;

  logic [CODE_W-1:0] bank_code [NBANK];
  logic              bank_en   [NBANK];
  logic [AW-1:0]     bank_addr [NBANK];
  logic [CTRL_W-1:0] bank_data [NBANK];

  cmf_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .wr_data(host_wr_data),
    .master_en(master_en), .sweep_last(sweep_last), .start_now(start_now),
    .abort_now(abort_now), .busy(busy), .done(done), .cfg(cfg),
    .rd_data(host_rd_data)
  );

  assign active = busy & ~abort_now;

  cmf_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start_now), .start_addr(slot_cnt),
    .step(active), .addr(sweep_addr), .last(sweep_last)
  );

  assign bank_code[0] = cfg.loc;
  assign bank_code[1] = cfg.bp;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cmf_mem_port #(.AW(AW)) u_port (
      .active(active), .addr(sweep_addr), .code(bank_code[b]),
      .wr_en(bank_en[b]), .wr_addr(bank_addr[b]), .wr_data(bank_data[b])
    );
  end

  assign loc_wr_en   = bank_en[0];
  assign loc_wr_addr = bank_addr[0];
  assign loc_wr_data = bank_data[0];
  assign bp_wr_en    = bank_en[1];
  assign bp_wr_addr  = bank_addr[1];
  assign bp_wr_data  = bank_data[1];
endmodule

// File: rtl/cmf_fill_engine_chk.sv
module cmf_fill_engine_chk #(
  parameter int DEPTH = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr_en,
  input logic [15:0]   host_wr_data,
  input logic [15:0]   host_rd_data,
  input logic          master_en,
  input logic [AW-1:0] slot_cnt,
  input logic          loc_wr_en,
  input logic [AW-1:0] loc_wr_addr,
  input logic [15:0]   loc_wr_data,
  input logic          bp_wr_en,
  input logic [AW-1:0] bp_wr_addr,
  input logic [15:0]   bp_wr_data,
  input logic          busy,
  input logic          done
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  int unsigned wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) wr_cnt <= 0;
    else if (loc_wr_en) wr_cnt <= wr_cnt + 1;
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_data[15:7] == 9'd0);
  a_r8_start_bit_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_data[0] == busy);
  a_r5_loc_word: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_en |-> (loc_wr_data[12:0] == 13'd0 && loc_wr_data[15:13] == host_rd_data[3:1]));
  a_r6_bp_word: assert property (@(posedge clk) disable iff (!rst_n)
    bp_wr_en |-> (bp_wr_data[12:0] == 13'd0 && bp_wr_data[15:13] == host_rd_data[6:4]));
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr_en && $past(loc_wr_en)) |->
      loc_wr_addr == (($past(loc_wr_addr) == TOP) ? '0 : $past(loc_wr_addr) + 1'b1));
  a_r7_banks_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_en == bp_wr_en && (!loc_wr_en || loc_wr_addr == bp_wr_addr));
  a_r7_write_limit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= DEPTH);
  a_r3_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> loc_wr_addr == $past(slot_cnt));
  a_r11_master_gates_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (!loc_wr_en && !bp_wr_en));
  a_r11_master_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !busy);
  a_r10_host_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr_en && !host_wr_data[0]) |-> !loc_wr_en);
  a_r10_host_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr_en && !host_wr_data[0]) |=> (!busy && !done));
  a_r9_codes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(host_rd_data[6:1]));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !loc_wr_en);
endmodule

bind cmf_fill_engine cmf_fill_engine_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
  .host_rd_data(host_rd_data), .master_en(master_en), .slot_cnt(slot_cnt),
  .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
  .bp_wr_en(bp_wr_en), .bp_wr_addr(bp_wr_addr), .bp_wr_data(bp_wr_data),
  .busy(busy), .done(done)
);

// File: tb/cmf_fill_engine_tb_top.sv
module cmf_fill_engine_tb_top;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr_en = 1'b0;
  logic [15:0] host_wr_data = '0;
  logic [15:0] host_rd_data;
  logic master_en = 1'b1;
  logic [AW-1:0] slot_cnt = '0;
  logic loc_wr_en, bp_wr_en, busy, done;
  logic [AW-1:0] loc_wr_addr, bp_wr_addr;
  logic [15:0] loc_wr_data, bp_wr_data;

  logic [15:0] mem_l [DEPTH];
  logic [15:0] mem_b [DEPTH];
  logic [15:0] exp_l [DEPTH];
  logic [15:0] exp_b [DEPTH];
  int strobes = 0;
  int vectors = 0, misses = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cmf_fill_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .master_en(master_en), .slot_cnt(slot_cnt),
    .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
    .bp_wr_en(bp_wr_en), .bp_wr_addr(bp_wr_addr), .bp_wr_data(bp_wr_data),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (loc_wr_en) begin mem_l[loc_wr_addr] <= loc_wr_data; strobes <= strobes + 1; end
    if (bp_wr_en) mem_b[bp_wr_addr] <= bp_wr_data;
  end

  function automatic logic [15:0] ctrl_word(input logic en, input logic [2:0] l, input logic [2:0] b);
    return {9'd0, b, l, en};
  endfunction

  function automatic logic [15:0] pat(input logic [2:0] c);
    return {c, 13'd0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  task automatic host_wr(input logic [15:0] w);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_data = w;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic cmp_mems(input string req);
    int bad_l = 0, bad_b = 0;
    for (int a = 0; a < DEPTH; a++) begin
      if (mem_l[a] !== exp_l[a]) bad_l++;
      if (mem_b[a] !== exp_b[a]) bad_b++;
    end
    chk({req, " local entries wrong"}, bad_l, 0);
    chk({req, " backplane entries wrong"}, bad_b, 0);
  endtask

  // mode 0: full sweep, 1: host stop, 2: master stop, 3: full sweep with ignored write at step k
  task automatic run_fill(input logic [2:0] l, input logic [2:0] b, input int slot,
                          input int mode, input int k);
    logic [15:0] junk;
    int n;
    slot_cnt = AW'(slot);
    host_wr(ctrl_word(1'b1, l, b));
    chk("R3 busy after start", busy, 1);
    chk("R3 read-back after start", host_rd_data, ctrl_word(1'b1, l, b));
    if (mode == 0 || mode == 3) begin
      for (int i = 0; i < DEPTH; i++) begin
        junk = 16'($urandom) | 16'h0001;
        host_wr_en = (mode == 3 && i == k);
        host_wr_data = junk;
        @(negedge clk);
      end
      host_wr_en = 1'b0;
      chk("R8 busy low at end", busy, 0);
      chk("R8 done pulse", done, 1);
      chk(mode == 3 ? "R9 codes kept after ignored write" : "R8 start bit cleared",
          host_rd_data, ctrl_word(1'b0, l, b));
      n = DEPTH;
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
    end else begin
      for (int i = 0; i < k; i++) @(negedge clk);
      if (mode == 1) begin
        host_wr_en = 1'b1;
        host_wr_data = 16'($urandom) & 16'hFFFE;
      end else begin
        master_en = 1'b0;
      end
      @(negedge clk);
      host_wr_en = 1'b0;
      master_en = 1'b1;
      chk(mode == 1 ? "R10 busy low after host stop" : "R11 busy low after master stop", busy, 0);
      chk(mode == 1 ? "R10 no done on stop" : "R11 no done on stop", done, 0);
      chk(mode == 1 ? "R10 codes kept" : "R11 codes kept", host_rd_data, ctrl_word(1'b0, l, b));
      n = k;
    end
    for (int i = 0; i < n; i++) begin
      exp_l[(slot + i) % DEPTH] = pat(l);
      exp_b[(slot + i) % DEPTH] = pat(b);
    end
    @(negedge clk);
    cmp_mems(mode == 0 || mode == 3 ? "R7 R5 R6" : "R12");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    int s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 read-back in reset", host_rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 read-back", host_rd_data, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 no writes", strobes, 0);

    // R2: idle write stores codes, reserved reads zero
    host_wr(16'hFF80 | ctrl_word(1'b0, 3'd5, 3'd2));
    chk("R2 idle write read-back", host_rd_data, ctrl_word(1'b0, 3'd5, 3'd2));

    // R4: start refused without master enable
    master_en = 1'b0;
    host_wr(ctrl_word(1'b1, 3'd6, 3'd1));
    chk("R4 no busy", busy, 0);
    chk("R4 codes stored, start bit low", host_rd_data, ctrl_word(1'b0, 3'd6, 3'd1));
    repeat (4) @(negedge clk);
    chk("R4 no writes", strobes, 0);
    master_en = 1'b1;

    // directed corners
    run_fill(3'd7, 3'd3, 0, 0, 0);
    run_fill(3'd2, 3'd5, DEPTH - 1, 0, 0);
    run_fill(3'd4, 3'd6, 7, 1, 0);
    run_fill(3'd1, 3'd7, 20, 2, DEPTH - 1);
    run_fill(3'd0, 3'd4, 11, 3, 3);

    // random mix
    for (int it = 0; it < 24; it++) begin
      s = int'($urandom % DEPTH);
      run_fill(3'($urandom), 3'($urandom), s, int'($urandom % 4), int'($urandom % DEPTH));
    end
    finish_run();
  end
endmodule